// File: doc/BRIEF.md
# Configurable Serial Transmit Shifter

This block sends one loaded word out of a single data pin, one bit at a time. It has no rate generator of its own. Each step comes either from a half-bit tick that a rate generator elsewhere on the chip supplies, or from either edge of an external clock pin after synchronisation. A step always marks half a bit time, so each bit lasts two steps. The first step marks a bit boundary and the second marks mid-bit. Software picks the frame length, the bit order and the fill value. It also chooses whether a start bit and a stop bit wrap the data, and whether a bit clock is driven on the pin just below the data pin.

With framing on, the block acts as an asynchronous transmitter. With framing off, it is a plain shift register, and in synchronous mode it drives its own clock for a serial peripheral. A zero fill value with framing on gives a break of exact length for single-wire automotive buses. The length register reads back as a count of the bits still to send, so software can tell when the line is free for half-duplex turnaround.

Top module: `ser_shift_tx`

## Requirements
- R1: After reset, `tx_done` is 1 and `busy_err` is 0. `len_rdata` reads 63 (the done code). `pin_data` equals `cfg_fill` and `pin_clk` equals `cfg_clk_idle`.
- R2: A write of value L on `len_wdata` with `len_wr` high sets the frame to L+1 data bits (L is 0..31, so 1 to 32 bits). The new length applies to frames loaded after the write.
- R3: With `cfg_msb_first`=0, data bit 0 goes first. With `cfg_msb_first`=1, data bit L goes first, down to bit 0. Bits of `load_data` above bit L are never sent.
- R4: Each shift fills the vacated end of the register with `cfg_fill`. Every bit after the last data bit, including the stop bit, therefore equals `cfg_fill`. While idle, `pin_data` equals `cfg_fill`.
- R5: With `cfg_frame_en`=1, a 0 start bit goes before the data and one stop bit goes after it, for L+3 bits in all. With `cfg_frame_en`=0, exactly L+1 bits are sent.
- R6: `len_rdata` reads 62 (the waiting code) from an accepted load until the first step. It then reads the number of bits still to send, counting the bit on the pin, and drops by one at each later bit boundary. It reads 63 (the done code) once the frame ends, and the next frame reloads the count from the length.
- R7: `pin_clk_oe` equals `cfg_sync_en`. `pin_clk` rests at `cfg_clk_idle`, goes to the other level at each mid-bit step, and returns at each bit boundary. `pin_data` changes only at bit boundaries.
- R8: With `cfg_ext_clk`=0, each `hbit_tick` pulse is a step. With `cfg_ext_clk`=1, each edge of `ext_clk_in` is a step, taken after a two-flop synchroniser.
- R9: A load while a frame is waiting or shifting is ignored and sets `busy_err`. `busy_err` holds until the next accepted load clears it.
- R10: `tx_done` is 0 from an accepted load until the bit boundary that follows the last bit. It is 1 at all other times.
- R11: A 32-bit framed frame of zeros with `cfg_fill`=0 holds `pin_data` low for exactly 34 bit times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_frame_en | input | 1 | Add start and stop bits |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_fill | input | 1 | Value shifted in behind the data; also the stop and idle level |
| cfg_sync_en | input | 1 | Drive the bit clock pin |
| cfg_clk_idle | input | 1 | Resting level of the bit clock |
| cfg_ext_clk | input | 1 | 1 = step on external clock edges |
| len_wr | input | 1 | Length register write strobe |
| len_wdata | input | 5 | Frame length minus one |
| len_rdata | output | 6 | Bits still to send, or the waiting/done code |
| hbit_tick | input | 1 | Internal half-bit step pulse |
| ext_clk_in | input | 1 | External clock pin |
| load | input | 1 | Load request |
| load_data | input | 32 | Word to send |
| pin_data | output | 1 | Serial data pin |
| pin_clk | output | 1 | Bit clock for the pin below the data pin |
| pin_clk_oe | output | 1 | Output enable for the clock pin |
| tx_done | output | 1 | Line free, no frame pending |
| busy_err | output | 1 | A load arrived while busy |

## Verification
The assertions assume that the configuration inputs stay steady from a load until `tx_done` rises. They also assume that steps arrive no faster than one per clock cycle and that `ext_clk_in` holds each level for several clock cycles. The bench keeps within these limits. It changes configuration only between frames and spaces each tick or external edge by at least three cycles. The only loads it issues during a frame are deliberate busy loads, and those come between steps.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } tx_state_e;

endpackage

// File: rtl/ser_step_src.sv
module ser_step_src (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_ext,
    input  logic tick,
    input  logic ext_in,
    output logic step
);
    logic s1_q, s2_q, s3_q;
    logic s1_d, s2_d, s3_d;

    always_comb begin
        s1_d = ext_in;
        s2_d = s1_q;
        s3_d = s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    // either edge of the synchronised external clock is one half-bit step
    assign step = sel_ext ? (s2_q ^ s3_q) : tick;

endmodule

// File: rtl/ser_word_align.sv
module ser_word_align #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LEN_W-1:0]  len,
    input  logic              msb_first,
    input  logic              fill,
    output logic [WORD_W-1:0] aligned
);
    localparam logic [WORD_W-1:0] ONES = '1;
    localparam logic [LEN_W-1:0]  TOP  = LEN_W'(WORD_W - 1);

    logic [LEN_W-1:0]  gap;
    logic [WORD_W-1:0] low_mask;
    logic [WORD_W-1:0] high_mask;

    always_comb begin
        gap       = TOP - len;
        low_mask  = ONES >> gap;
        high_mask = ONES << gap;
        if (msb_first) begin
            // frame MSB lands at the top, fill occupies the freed low end
            aligned = (word << gap) | (fill ? ~high_mask : '0);
        end else begin
            aligned = (word & low_mask) | (fill ? ~low_mask : '0);
        end
    end

endmodule

// File: rtl/ser_shift_tx.sv
module ser_shift_tx
    import ser_tx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = $clog2(WORD_W),
    parameter int CNT_W  = $clog2(WORD_W + 5)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_frame_en,
    input  logic              cfg_msb_first,
    input  logic              cfg_fill,
    input  logic              cfg_sync_en,
    input  logic              cfg_clk_idle,
    input  logic              cfg_ext_clk,
    input  logic              len_wr,
    input  logic [LEN_W-1:0]  len_wdata,
    output logic [CNT_W-1:0]  len_rdata,
    input  logic              hbit_tick,
    input  logic              ext_clk_in,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    output logic              pin_data,
    output logic              pin_clk,
    output logic              pin_clk_oe,
    output logic              tx_done,
    output logic              busy_err
);
    localparam logic [CNT_W-1:0] RB_DONE = '1;
    localparam logic [CNT_W-1:0] RB_WAIT = {{(CNT_W-1){1'b1}}, 1'b0};
    localparam logic [CNT_W-1:0] MAX_BITS = CNT_W'(WORD_W + 2);

    typedef struct packed {
        tx_state_e         st;
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  rem;
        logic              start_pend;
        logic              ph;
        logic              out;
        logic              clk_act;
        logic              err;
        logic [LEN_W-1:0]  len;
    } regs_t;

    localparam regs_t RST_VAL = '{
        st: ST_IDLE, sh: '0, rem: '0, start_pend: 1'b0, ph: 1'b0,
        out: 1'b1, clk_act: 1'b0, err: 1'b0, len: '1
    };

    regs_t q, d;
    logic              step;
    logic [WORD_W-1:0] aligned;
    logic [CNT_W-1:0]  frame_bits;
    logic              cur_bit;
    logic [WORD_W-1:0] shifted;

    ser_step_src u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_ext (cfg_ext_clk),
        .tick    (hbit_tick),
        .ext_in  (ext_clk_in),
        .step    (step)
    );

    ser_word_align #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_align (
        .word      (load_data),
        .len       (q.len),
        .msb_first (cfg_msb_first),
        .fill      (cfg_fill),
        .aligned   (aligned)
    );

    always_comb begin
        frame_bits = CNT_W'(q.len) + CNT_W'(1) + (cfg_frame_en ? CNT_W'(2) : CNT_W'(0));
        cur_bit    = cfg_msb_first ? q.sh[WORD_W-1] : q.sh[0];
        shifted    = cfg_msb_first ? {q.sh[WORD_W-2:0], cfg_fill}
                                   : {cfg_fill, q.sh[WORD_W-1:1]};
    end

    always_comb begin
        d = q;
        if (len_wr) begin
            d.len = len_wdata;
        end
        unique case (q.st)
            ST_IDLE: begin
                d.clk_act = 1'b0;
                if (load) begin
                    d.st         = ST_WAIT;
                    d.sh         = aligned;
                    d.rem        = frame_bits;
                    d.start_pend = cfg_frame_en;
                    d.ph         = 1'b0;
                    d.err        = 1'b0;
                end
            end
            ST_WAIT: begin
                if (load) begin
                    d.err = 1'b1;
                end
                if (step) begin
                    d.st = ST_SHIFT;
                    d.ph = 1'b1;
                    if (q.start_pend) begin
                        d.out        = 1'b0;
                        d.start_pend = 1'b0;
                    end else begin
                        d.out = cur_bit;
                        d.sh  = shifted;
                    end
                end
            end
            ST_SHIFT: begin
                if (load) begin
                    d.err = 1'b1;
                end
                if (step) begin
                    if (q.ph) begin
                        d.clk_act = 1'b1;
                        d.ph      = 1'b0;
                    end else begin
                        d.clk_act = 1'b0;
                        if (q.rem == CNT_W'(1)) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.rem = q.rem - CNT_W'(1);
                            d.ph  = 1'b1;
                            if (q.start_pend) begin
                                d.out        = 1'b0;
                                d.start_pend = 1'b0;
                            end else begin
                                d.out = cur_bit;
                                d.sh  = shifted;
                            end
                        end
                    end
                end
            end
            default: d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.st)
            ST_IDLE:  len_rdata = RB_DONE;
            ST_WAIT:  len_rdata = RB_WAIT;
            default:  len_rdata = q.rem;
        endcase
    end

    assign pin_data   = (q.st == ST_IDLE) ? cfg_fill : q.out;
    assign pin_clk    = q.clk_act ^ cfg_clk_idle;
    assign pin_clk_oe = cfg_sync_en;
    assign tx_done    = (q.st == ST_IDLE);
    assign busy_err   = q.err;

    AST_REM_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && step && !q.ph && q.rem > CNT_W'(1)) |=> (len_rdata == $past(q.rem) - CNT_W'(1))); // R6
    AST_REM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT) |-> (q.rem != '0 && q.rem <= MAX_BITS)); // R6
    AST_DATA_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && step && q.ph) |=> $stable(pin_data)); // R7
    AST_CLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_SHIFT) |-> (pin_clk == cfg_clk_idle)); // R7
    AST_BUSY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && q.st != ST_IDLE) |=> busy_err); // R9
    AST_LAST_BIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && step && !q.ph && q.rem == CNT_W'(1)) |=> tx_done); // R10

endmodule

// File: tb/ser_shift_tx_test.sv
`timescale 1ns/1ps
module ser_shift_tx_test;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_frame_en = 1'b0, cfg_msb_first = 1'b0, cfg_fill = 1'b1;
    logic cfg_sync_en = 1'b0, cfg_clk_idle = 1'b0, cfg_ext_clk = 1'b0;
    logic len_wr = 1'b0;
    logic [4:0] len_wdata = '0;
    logic [5:0] len_rdata;
    logic hbit_tick = 1'b0, ext_clk_in = 1'b0, load = 1'b0;
    logic [W-1:0] load_data = '0;
    logic pin_data, pin_clk, pin_clk_oe, tx_done, busy_err;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    bit exp_q[$];
    string cur_req = "R1";
    logic prev_clk = 1'b0;

    always #2.5 clk = ~clk;

    ser_shift_tx #(.WORD_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_frame_en(cfg_frame_en), .cfg_msb_first(cfg_msb_first), .cfg_fill(cfg_fill),
        .cfg_sync_en(cfg_sync_en), .cfg_clk_idle(cfg_clk_idle), .cfg_ext_clk(cfg_ext_clk),
        .len_wr(len_wr), .len_wdata(len_wdata), .len_rdata(len_rdata),
        .hbit_tick(hbit_tick), .ext_clk_in(ext_clk_in),
        .load(load), .load_data(load_data),
        .pin_data(pin_data), .pin_clk(pin_clk), .pin_clk_oe(pin_clk_oe),
        .tx_done(tx_done), .busy_err(busy_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: at each active clock edge pop the expected bit and compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_clk == cfg_clk_idle && pin_clk != cfg_clk_idle) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected clock pulse", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(pin_data == e, cur_req, "serial bit", pin_data, e);
                end
            end
        end
        prev_clk = pin_clk;
    end

    task automatic half_step(input bit ext);
        if (!ext) begin
            @(negedge clk) hbit_tick = 1'b1;
            @(negedge clk) hbit_tick = 1'b0;
            repeat (2) @(negedge clk);
        end else begin
            @(negedge clk) ext_clk_in = ~ext_clk_in;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic send(input logic [W-1:0] dat, input int n, input bit framed,
                        input bit msb, input bit fill, input bit sync, input bit idle,
                        input bit ext, input bit poke, input string req);
        int total;
        @(negedge clk);
        cfg_frame_en = framed; cfg_msb_first = msb; cfg_fill = fill;
        cfg_sync_en = sync; cfg_clk_idle = idle; cfg_ext_clk = ext;
        cur_req = req;
        len_wr = 1'b1; len_wdata = 5'(n - 1);
        @(negedge clk) len_wr = 1'b0;
        chk(pin_clk_oe == sync, "R7", "clock enable", pin_clk_oe, sync);
        chk(pin_data == fill, "R4", "idle level", pin_data, fill);
        if (framed) exp_q.push_back(1'b0);
        for (int i = 0; i < n; i++) exp_q.push_back(msb ? dat[n-1-i] : dat[i]);
        if (framed) exp_q.push_back(fill);
        total = n + (framed ? 2 : 0);
        load = 1'b1; load_data = dat;
        @(negedge clk) load = 1'b0;
        chk(len_rdata == 6'd62, "R6", "waiting code", len_rdata, 62);
        chk(tx_done == 1'b0, "R10", "done during frame", tx_done, 0);
        chk(busy_err == 1'b0, "R9", "error cleared on load", busy_err, 0);
        for (int k = 0; k < 2 * total + 1; k++) begin
            half_step(ext);
            if (k == 0) chk(len_rdata == 6'(total), "R6", "initial count", len_rdata, total);
            if (k == 2 && total > 1)
                chk(len_rdata == 6'(total - 1), "R6", "count after one bit", len_rdata, total - 1);
            if (poke && k == 3) begin
                @(negedge clk) begin load = 1'b1; load_data = ~dat; end
                @(negedge clk) load = 1'b0;
                chk(busy_err == 1'b1, "R9", "busy error", busy_err, 1);
            end
        end
        repeat (3) @(negedge clk);
        chk(tx_done == 1'b1, "R10", "done after frame", tx_done, 1);
        chk(len_rdata == 6'd63, "R6", "done code", len_rdata, 63);
        chk(pin_data == fill, "R4", "line after frame", pin_data, fill);
        chk(pin_clk == idle, "R7", "clock rests", pin_clk, idle);
        chk(exp_q.size() == 0, req, "bits left unsent", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_done == 1'b1, "R1", "done at reset", tx_done, 1);
        chk(busy_err == 1'b0, "R1", "error at reset", busy_err, 0);
        chk(len_rdata == 6'd63, "R1", "readback at reset", len_rdata, 63);
        chk(pin_data == 1'b1, "R1", "data idle", pin_data, 1);
        chk(pin_clk == 1'b0, "R1", "clock idle", pin_clk, 0);

        send(32'h0000_00A5, 8,  1, 0, 1, 0, 0, 0, 0, "R5");
        send(32'h0000_003C, 8,  0, 1, 1, 1, 0, 0, 0, "R3");
        send(32'hDEAD_BEEF, 32, 0, 0, 0, 1, 1, 0, 0, "R2");
        send(32'h0000_0001, 1,  1, 0, 1, 1, 0, 0, 0, "R2");
        send(32'hFFFF_F5A3, 12, 1, 1, 0, 1, 1, 0, 0, "R4");
        send(32'h0000_0016, 5,  0, 0, 1, 1, 0, 1, 0, "R8");
        send(32'h0000_005A, 8,  1, 0, 1, 0, 0, 0, 1, "R9");
        send(32'h0000_0000, 32, 1, 0, 0, 1, 0, 0, 0, "R11");
        send(32'h8000_0001, 32, 1, 1, 1, 1, 1, 1, 0, "R3");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule